// File: doc/BRIEF.md
# Multi-Channel Reload Down-Counter Timer

This block is a memory-mapped timer with two or three independent 32-bit channels. Each channel owns a down-counter, a reload value and a control word. The control word chooses a prescaled count clock, enables the channel's interrupt and holds a sticky underflow flag. When a running counter steps below zero, the channel reloads its counter from the reload value and raises the flag, so software gets a periodic event with no further action.

A single byte-wide run register carries one start bit per channel. Software starts or stops any mix of channels with one write. Each channel drives its own level-sensitive interrupt line. The register bus is a simple synchronous port with byte enables: writes take effect at the clock edge and reads are combinational.

Top module: `reload_timer`

## Requirements
- R1: Register offsets are fixed. The run register is at byte 4, in bits [NCH-1:0]. For channel n the reload value is at 8+12n, the counter at 12+12n and the control word at 16+12n. Unused bits read as zero.
- R2: Run bit n set makes channel n count. While the bit is clear the counter holds its value and software writes to the counter still take effect.
- R3: Control bits [2:0] select a count-clock ratio: code 0 gives 4 cycles, 1 gives 16, 2 gives 64, 3 gives 256 and 4 gives 1024. Codes 5, 6 and 7 act as code 0. The first tick comes one full ratio after the channel starts or after its code changes.
- R4: Each tick decrements the counter by one. A tick at zero loads the reload value and sets the underflow flag (control bit 8) in the same cycle. A start with counter C therefore gives the first underflow (C+1)×ratio cycles later, and each later one (reload+1)×ratio cycles apart.
- R5: The underflow flag is sticky. A control write with bit 8 at zero (byte lane 1 enabled) clears it. Writing a one leaves it unchanged. An underflow in the same cycle wins over the clear.
- R6: Interrupt line n is high exactly while channel n's flag and its enable (control bit 5) are both set.
- R7: Byte enable k writes data bits [8k+7:8k] only. Other bytes keep their value.
- R8: After reset, reload values and counters are all ones. The control words and the run register are zero, and no interrupt is raised.
- R9: Channels are independent. Activity on one channel leaves the others' counters, flags and interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock feeding the prescalers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address (word-aligned decode) |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | NCH | One interrupt level per channel |

## Verification
The underflow timing is measured as the cycle count from start to interrupt. The pairs of ratio code and start value are chosen so that an off-by-one in the tick count and a wrong divider ratio give different counts, including the reserved codes and the largest ratio with a zero start value. A second interval after a reload separates the reload value from the start value. Directed cases cover interrupt gating without the enable, a flag write of one that must not set the flag, a clear that skips byte lane 1, and partial-byte counter writes while stopped. Another channel runs during these cases to show that the channels are independent.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int NCH = 3,
  parameter int AW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NCH-1:0]  irq
);
  localparam int PW = 10;
  localparam int IW = AW - 2;

  logic [NCH-1:0]        start_q;
  logic [NCH-1:0]        tick, flag_q, wr_cnt, wr_ctl;
  logic [NCH-1:0][31:0]  cnt_q, rd_ch;

  wire          wr   = bus_en & bus_we;
  wire [IW-1:0] widx = bus_addr[AW-1:2];
  wire          run_hit = (widx == IW'(1));

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] w,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int k = 0; k < 4; k++)
      if (be[k]) r[8*k +: 8] = w[8*k +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= '0;
    else if (wr && run_hit && bus_be[0]) start_q <= bus_wdata[NCH-1:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int BASE = 2 + 3 * ch;
    logic [31:0]   cst_r, cnt_r;
    logic [2:0]    psc_r;
    logic          ie_r, flag_r;
    logic [PW-1:0] pre_r, lim;
    logic          hit_cst, hit_cnt, hit_ctl, psc_chg, under;

    assign hit_cst = (widx == IW'(BASE));
    assign hit_cnt = (widx == IW'(BASE + 1));
    assign hit_ctl = (widx == IW'(BASE + 2));
    assign wr_cnt[ch] = wr & hit_cnt;
    assign wr_ctl[ch] = wr & hit_ctl;
    assign psc_chg = wr_ctl[ch] & bus_be[0] & (bus_wdata[2:0] != psc_r);

    always_comb begin
      case (psc_r)
        3'd1:    lim = PW'(15);
        3'd2:    lim = PW'(63);
        3'd3:    lim = PW'(255);
        3'd4:    lim = PW'(1023);
        default: lim = PW'(3);
      endcase
    end

    assign tick[ch] = start_q[ch] & (pre_r == lim);
    assign under    = tick[ch] & (cnt_r == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pre_r  <= '0;
        cst_r  <= '1;
        cnt_r  <= '1;
        psc_r  <= '0;
        ie_r   <= 1'b0;
        flag_r <= 1'b0;
      end else begin
        if (!start_q[ch] || psc_chg || tick[ch]) pre_r <= '0;
        else pre_r <= pre_r + 1'b1;
        if (wr && hit_cst) cst_r <= merge(cst_r, bus_wdata, bus_be);
        if (wr_cnt[ch])    cnt_r <= merge(cnt_r, bus_wdata, bus_be);
        else if (under)    cnt_r <= cst_r;
        else if (tick[ch]) cnt_r <= cnt_r - 1'b1;
        if (wr_ctl[ch] && bus_be[0]) begin
          psc_r <= bus_wdata[2:0];
          ie_r  <= bus_wdata[5];
        end
        if (under) flag_r <= 1'b1;
        else if (wr_ctl[ch] && bus_be[1] && !bus_wdata[8]) flag_r <= 1'b0;
      end
    end

    assign cnt_q[ch]  = cnt_r;
    assign flag_q[ch] = flag_r;
    assign irq[ch]    = flag_r & ie_r;
    assign rd_ch[ch]  = hit_cst ? cst_r :
                        hit_cnt ? cnt_r :
                        hit_ctl ? {23'b0, flag_r, 2'b0, ie_r, 2'b0, psc_r} : 32'b0;
  end

  always_comb begin
    bus_rdata = run_hit ? 32'(start_q) : 32'b0;
    for (int i = 0; i < NCH; i++) bus_rdata = bus_rdata | rd_ch[i];
  end
endmodule

module reload_timer_chk #(
  parameter int NCH = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       start_q,
  input logic [NCH-1:0]       tick,
  input logic [NCH-1:0]       wr_cnt,
  input logic [NCH-1:0]       wr_ctl,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_wdata,
  input logic [NCH-1:0][31:0] cnt_q,
  input logic [NCH-1:0]       flag_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[c] && !wr_cnt[c]) |=> $stable(cnt_q[c]));
    assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |-> start_q[c]);
    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && cnt_q[c] != 32'd0 && !wr_cnt[c]) |=> (cnt_q[c] == $past(cnt_q[c]) - 32'd1));
    assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[c]) |-> ($past(tick[c]) && $past(cnt_q[c]) == 32'd0));
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl[c] && bus_be[1] && !bus_wdata[8] && !(tick[c] && cnt_q[c] == 32'd0))
        |=> !flag_q[c]);
  end
endmodule

bind reload_timer reload_timer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_q(start_q), .tick(tick), .wr_cnt(wr_cnt),
  .wr_ctl(wr_ctl), .bus_be(bus_be), .bus_wdata(bus_wdata), .cnt_q(cnt_q),
  .flag_q(flag_q));

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int AW  = 8;
  localparam int NV  = 6;
  // {ratio code, start/reload value, cycles from start to first underflow}
  localparam int unsigned TV [NV][3] = '{
    '{0, 3, 16}, '{1, 2, 48}, '{2, 1, 128}, '{5, 2, 12}, '{4, 0, 1024}, '{3, 1, 512}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] irq;
  int n_chk = 0, n_bad = 0;

  reload_timer #(.NCH(NCH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic wait_irq0(output int n);
    n = 0;
    while (!irq[0] && n < 5000) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset values
    rd(8, d);  check("R8 reload reset", d, 32'hFFFF_FFFF);
    rd(12, d); check("R8 counter reset", d, 32'hFFFF_FFFF);
    rd(16, d); check("R8 control reset", d, 32'h0);
    rd(4, d);  check("R8 run reset", d, 32'h0);
    check("R8 irq reset", 32'(irq), 32'h0);

    // R3/R4 table: ratio codes and start values on channel 0
    for (int v = 0; v < NV; v++) begin
      wr(4, 32'h0);
      wr(16, 32'h20 | TV[v][0]);
      wr(8, TV[v][1]);
      wr(12, TV[v][1]);
      wr(4, 32'h1);
      wait_irq0(n);
      check($sformatf("R3 R4 vec%0d underflow cycles", v), n, TV[v][2]);
      rd(12, d); check($sformatf("R4 vec%0d reloaded", v), d, TV[v][1]);
    end

    // R5 clear and write-one-ignored
    wr(4, 32'h0);
    wr(16, 32'h20);
    check("R5 clear drops irq", 32'(irq[0]), 32'h0);
    wr(16, 32'h120);
    check("R5 write one ignored irq", 32'(irq[0]), 32'h0);
    rd(16, d); check("R5 control readback", d, 32'h20);

    // R6/R7/R9: channel 1 runs without enable; channel 0 stays stopped
    rd(12, d2);
    wr(28, 32'h0);
    wr(20, 32'h0);
    wr(24, 32'h0);
    wr(4, 32'h2);
    repeat (12) @(negedge clk);
    rd(28, d); check("R4 ch1 flag set", d, 32'h100);
    check("R6 no irq without enable", 32'(irq[1]), 32'h0);
    wr(28, 32'h20, 4'b0001);
    check("R6 R7 enable via lane0 only", 32'(irq[1]), 32'h1);
    rd(4, d); check("R1 run register readback", d, 32'h2);
    rd(12, d); check("R9 ch0 counter untouched", d, d2);
    check("R9 ch0 irq quiet", 32'(irq[0]), 32'h0);

    // R2/R7 stopped hold and writes
    wr(4, 32'h0);
    wr(12, 32'h1234_5678);
    repeat (20) @(negedge clk);
    rd(12, d); check("R2 stopped counter written and held", d, 32'h1234_5678);
    wr(12, 32'hAABB_CCDD, 4'b0100);
    rd(12, d); check("R7 byte lane 2 write", d, 32'h12BB_5678);

    // R4 periodic reload interval
    wr(16, 32'h20);
    wr(8, 32'd5);
    wr(12, 32'd1);
    wr(4, 32'h1);
    wait_irq0(n);
    check("R4 first interval", n, 8);
    wr(16, 32'h20);
    wait_irq0(n);
    check("R4 reload interval", n, 22);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule